// File: doc/BRIEF.md
# Sleep-State Rail Decoder

This block turns the two active-low sleep request lines of a power-managed system into on/off commands for three supply planes: a 3.3 V dual plane, a 5 V dual plane and a memory plane. Each plane has two switches. The active-path switch feeds the plane from the main supply. The sleep-path switch feeds it from the standby supply or from an internal element. The block registers the request lines through a two-flop synchronizer. It waits until a new request has held still for a deglitch window, measured in timebase ticks, and only then adopts it. It refuses request codes that are not allowed and refuses jumps between the two sleep depths.

Two configuration bits select which dual planes survive sleep. The block captures them while it runs or is halted, and holds them frozen while it sleeps. A memory-voltage select bit is captured on each power-on release pulse. A shutdown flag forces every switch off. When the flag drops, the block decodes the request lines again from scratch. Analog regulation and the pass elements sit outside this block.

Top module: `sleep_rail_ctl`

## Requirements
- R1: After reset and until the first `por_rel` pulse, `state_o` is 0 (OFF) and all six switch outputs are 0.
- R2: On a `por_rel` pulse, or on leaving shutdown, the state is decoded directly from the synchronized request pair {`req_s5_n`,`req_s3_n`}: 11 gives RUN (code 1), 10 gives LIGHT sleep (code 2), and anything else gives DEEP sleep (code 3).
- R3: From RUN, LIGHT or DEEP, a new request pair is adopted only after it has stayed unchanged for DG_TICKS ticks. A pulse shorter than the window leaves the state unchanged. Any change during the window restarts it, so a fall of S3 shortly ahead of S5 ends in DEEP and never passes through LIGHT.
- R4: The pair 01 (`req_s5_n`=0, `req_s3_n`=1) is never adopted; the current state is kept.
- R5: LIGHT never moves to DEEP and DEEP never moves to LIGHT; only moves to and from RUN are taken.
- R6: 3.3 V dual plane: the active switch is on in RUN and the sleep switch is on in LIGHT. In DEEP the sleep switch is on only if the latched `d33_drop_deep` is 0.
- R7: 5 V dual plane: the active switch is on in RUN. In LIGHT and DEEP the sleep switch is on only if the latched `d5_keep_sleep` is 1.
- R8: Memory plane: the active switch is on in RUN, the sleep switch is on in LIGHT, and both are off in DEEP.
- R9: No plane ever has both switches on at once. When a plane moves from its active switch to its sleep switch, at least one cycle with both switches off comes between them.
- R10: `d33_drop_deep` and `d5_keep_sleep` are followed while in OFF, RUN or shutdown, and are captured on the cycle the block leaves those states. Changes to them while in LIGHT or DEEP have no effect on the outputs.
- R11: `shutdown`=1 while in RUN, LIGHT or DEEP moves the block to shutdown (code 4) on the next edge and turns all switches off. Releasing it re-decodes the state as in R2.
- R12: `mem_sel_o` takes `mem_sel` only on a `por_rel` pulse and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase pulse that paces the deglitch window |
| req_s3_n | input | 1 | Light-sleep request, active low |
| req_s5_n | input | 1 | Deep-sleep request, active low |
| d33_drop_deep | input | 1 | 1: 3.3 V dual plane off in deep sleep |
| d5_keep_sleep | input | 1 | 1: 5 V dual plane kept in sleep |
| mem_sel | input | 1 | Memory voltage select |
| por_rel | input | 1 | Power-on release pulse |
| shutdown | input | 1 | Forces all planes off |
| d33_act | output | 1 | 3.3 V dual active-path switch |
| d33_slp | output | 1 | 3.3 V dual sleep-path switch |
| d5_act | output | 1 | 5 V dual active-path switch |
| d5_slp | output | 1 | 5 V dual sleep-path switch |
| mem_act | output | 1 | Memory active-path switch |
| mem_slp | output | 1 | Memory sleep-path switch |
| mem_sel_o | output | 1 | Latched memory voltage select |
| state_o | output | 3 | State code: 0 OFF, 1 RUN, 2 LIGHT, 3 DEEP, 4 shutdown |

## Verification
Two events can land in the same cycle: the deglitch window expiring, and a state change that moves a plane from its active switch to its sleep switch. The bench sets up that case with RUN-to-sleep entries, including one where the two request lines fall a few ticks apart. A per-cycle monitor then confirms that no plane turns its sleep switch on in the cycle right after its active switch was on. The same skewed entry is also checked for any visit to LIGHT. The check is that the block reaches DEEP with no intermediate LIGHT state and with the break-before-make gap kept on every plane.

// File: rtl/slr_pkg.sv
package slr_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_RUN   = 3'd1,
        ST_LIGHT = 3'd2,
        ST_DEEP  = 3'd3,
        ST_HALT  = 3'd4
    } slr_state_e;

    localparam int NUM_PLANES = 3;
    localparam int PL_D33     = 0;
    localparam int PL_D5      = 1;
    localparam int PL_MEM     = 2;

    typedef struct packed {
        slr_state_e st;
        logic       drop33;
        logic       keep5;
        logic       vsel;
    } slr_ctl_t;

    // request pair is {s5_n, s3_n}
    function automatic slr_state_e req_to_state(input logic [1:0] req);
        if (req == 2'b11)      return ST_RUN;
        else if (req == 2'b10) return ST_LIGHT;
        else                   return ST_DEEP;
    endfunction

    function automatic logic [1:0] state_to_req(input slr_state_e st);
        case (st)
            ST_LIGHT: return 2'b10;
            ST_DEEP:  return 2'b00;
            default:  return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/slr_sync.sv
module slr_sync #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q, s1_d, s2_q, s2_d;

    always_comb begin
        s1_d = din;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/slr_deglitch.sv
module slr_deglitch #(
    parameter int DG_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hold,
    input  logic [1:0] req,
    input  logic [1:0] cur,
    output logic       expire
);
    localparam int CW = $clog2(DG_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DG_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    prev;
    } dg_t;

    dg_t q, d;
    logic exp_c;

    always_comb begin
        d      = q;
        d.prev = req;
        exp_c  = 1'b0;
        if (hold || (req != q.prev) || (req == cur)) begin
            d.cnt = '0;
        end else if (tick) begin
            if (q.cnt == LAST) begin
                exp_c = 1'b1;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt  <= '0;
            q.prev <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign expire = exp_c;
endmodule

// File: rtl/slr_switch.sv
module slr_switch (
    input  logic clk,
    input  logic rst_n,
    input  logic want_act,
    input  logic want_slp,
    output logic act_o,
    output logic slp_o
);
    typedef struct packed {
        logic act;
        logic slp;
    } sw_t;

    sw_t q, d;

    always_comb begin
        // one side may turn on only after the other was off
        d.act = want_act & ~q.slp;
        d.slp = want_slp & ~q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign act_o = q.act;
    assign slp_o = q.slp;
endmodule

// File: rtl/sleep_rail_ctl.sv
module sleep_rail_ctl
    import slr_pkg::*;
#(
    parameter int DG_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       req_s3_n,
    input  logic       req_s5_n,
    input  logic       d33_drop_deep,
    input  logic       d5_keep_sleep,
    input  logic       mem_sel,
    input  logic       por_rel,
    input  logic       shutdown,
    output logic       d33_act,
    output logic       d33_slp,
    output logic       d5_act,
    output logic       d5_slp,
    output logic       mem_act,
    output logic       mem_slp,
    output logic       mem_sel_o,
    output logic [2:0] state_o
);
    logic [1:0] req_sy;
    logic       expire;
    logic       halted;
    slr_ctl_t   q, d;
    logic [NUM_PLANES-1:0] want_act, want_slp, act_w, slp_w;

    slr_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({req_s5_n, req_s3_n}),
        .dout (req_sy)
    );

    assign halted = (q.st == ST_OFF) || (q.st == ST_HALT);

    slr_deglitch #(.DG_TICKS(DG_TICKS)) u_dg (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .hold  (halted),
        .req   (req_sy),
        .cur   (state_to_req(q.st)),
        .expire(expire)
    );

    // next-state and configuration capture
    always_comb begin
        d = q;
        if (q.st inside {ST_OFF, ST_RUN, ST_HALT}) begin
            d.drop33 = d33_drop_deep;
            d.keep5  = d5_keep_sleep;
        end
        if (shutdown && (q.st != ST_OFF)) begin
            d.st = ST_HALT;
        end else if (por_rel) begin
            d.st   = req_to_state(req_sy);
            d.vsel = mem_sel;
        end else if (q.st == ST_HALT) begin
            d.st = req_to_state(req_sy);
        end else if (expire) begin
            case (q.st)
                ST_RUN: begin
                    if (req_sy == 2'b10)      d.st = ST_LIGHT;
                    else if (req_sy == 2'b00) d.st = ST_DEEP;
                end
                ST_LIGHT, ST_DEEP: begin
                    if (req_sy == 2'b11) d.st = ST_RUN;
                end
                default: d.st = q.st;
            endcase
        end
    end

    // plane demand from registered state
    always_comb begin
        want_act = '0;
        want_slp = '0;
        case (q.st)
            ST_RUN: want_act = '1;
            ST_LIGHT: begin
                want_slp[PL_D33] = 1'b1;
                want_slp[PL_D5]  = q.keep5;
                want_slp[PL_MEM] = 1'b1;
            end
            ST_DEEP: begin
                want_slp[PL_D33] = ~q.drop33;
                want_slp[PL_D5]  = q.keep5;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_OFF;
            q.drop33 <= 1'b0;
            q.keep5  <= 1'b0;
            q.vsel   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
        slr_switch u_sw (
            .clk     (clk),
            .rst_n   (rst_n),
            .want_act(want_act[p]),
            .want_slp(want_slp[p]),
            .act_o   (act_w[p]),
            .slp_o   (slp_w[p])
        );
    end

    assign d33_act   = act_w[PL_D33];
    assign d33_slp   = slp_w[PL_D33];
    assign d5_act    = act_w[PL_D5];
    assign d5_slp    = slp_w[PL_D5];
    assign mem_act   = act_w[PL_MEM];
    assign mem_slp   = slp_w[PL_MEM];
    assign mem_sel_o = q.vsel;
    assign state_o   = q.st;
endmodule

// File: rtl/slr_chk.sv
module slr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       shutdown,
    input logic       d33_act,
    input logic       d33_slp,
    input logic       d5_act,
    input logic       d5_slp,
    input logic       mem_act,
    input logic       mem_slp,
    input logic [2:0] state_o
);
    logic any_on;
    assign any_on = d33_act | d33_slp | d5_act | d5_slp | mem_act | mem_slp;

    assert_off_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0) |-> !any_on);

    assert_no_light_to_deep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2) |=> (state_o != 3'd3));

    assert_no_deep_to_light_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3) |=> (state_o != 3'd2));

    assert_mem_deep_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd3) && $past(state_o == 3'd3)) |-> (!mem_act && !mem_slp));

    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(d33_act && d33_slp) && !(d5_act && d5_slp) && !(mem_act && mem_slp));

    assert_gap_d33_R9: assert property (@(posedge clk) disable iff (!rst_n)
        d33_act |=> !d33_slp);

    assert_gap_d5_R9: assert property (@(posedge clk) disable iff (!rst_n)
        d5_act |=> !d5_slp);

    assert_gap_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_act |=> !mem_slp);

    assert_halt_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && (state_o inside {3'd1, 3'd2, 3'd3})) |=> (state_o == 3'd4));

    assert_halt_dark_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd4) && $past(state_o == 3'd4)) |-> !any_on);
endmodule

bind sleep_rail_ctl slr_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .shutdown(shutdown),
    .d33_act (d33_act),
    .d33_slp (d33_slp),
    .d5_act  (d5_act),
    .d5_slp  (d5_slp),
    .mem_act (mem_act),
    .mem_slp (mem_slp),
    .state_o (state_o)
);

// File: tb/sleep_rail_ctl_test.sv
`timescale 1ns/1ps
module sleep_rail_ctl_test;
    localparam int DG_TICKS = 4;
    localparam int TICK_GAP = 10;
    localparam int SETTLE   = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic req_s3_n = 1'b1, req_s5_n = 1'b1;
    logic d33_drop_deep = 1'b1, d5_keep_sleep = 1'b1;
    logic mem_sel = 1'b1, por_rel = 1'b0, shutdown = 1'b0;
    logic d33_act, d33_slp, d5_act, d5_slp, mem_act, mem_slp, mem_sel_o;
    logic [2:0] state_o;

    int checks = 0;
    int fails = 0;
    int bbm_err = 0;
    bit saw_light = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sleep_rail_ctl #(.DG_TICKS(DG_TICKS)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .req_s3_n(req_s3_n), .req_s5_n(req_s5_n),
        .d33_drop_deep(d33_drop_deep), .d5_keep_sleep(d5_keep_sleep),
        .mem_sel(mem_sel), .por_rel(por_rel), .shutdown(shutdown),
        .d33_act(d33_act), .d33_slp(d33_slp), .d5_act(d5_act), .d5_slp(d5_slp),
        .mem_act(mem_act), .mem_slp(mem_slp), .mem_sel_o(mem_sel_o),
        .state_o(state_o)
    );

    // timebase
    initial begin
        forever begin
            repeat (TICK_GAP - 1) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    // break-before-make and LIGHT-visit monitor
    initial begin
        logic [2:0] pa;
        pa = '0;
        forever begin
            @(negedge clk);
            if ((d33_act && d33_slp) || (d5_act && d5_slp) || (mem_act && mem_slp)) bbm_err++;
            if ((pa[0] && d33_slp) || (pa[1] && d5_slp) || (pa[2] && mem_slp)) bbm_err++;
            pa = {mem_act, d5_act, d33_act};
            if (state_o == 3'd2) saw_light = 1'b1;
        end
    end

    function automatic logic [5:0] exp_sw(input int st, input bit drop33, input bit keep5);
        case (st)
            1: return 6'b101010;
            2: return {1'b0, 1'b1, 1'b0, keep5, 1'b0, 1'b1};
            3: return {1'b0, ~drop33, 1'b0, keep5, 1'b0, 1'b0};
            default: return 6'b000000;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rails(input string req, input int st, input bit drop33, input bit keep5);
        chk({req, " state"}, state_o, st);
        chk({req, " switches"}, {d33_act, d33_slp, d5_act, d5_slp, mem_act, mem_slp},
            exp_sw(st, drop33, keep5));
    endtask

    task automatic set_req(input bit s5, input bit s3);
        req_s5_n = s5;
        req_s3_n = s3;
    endtask

    task automatic pulse_por();
        por_rel = 1'b1;
        wait_cyc(1);
        por_rel = 1'b0;
    endtask

    task automatic t_reset();
        wait_cyc(5);
        expect_rails("R1", 0, 1, 1);
    endtask

    task automatic t_power_up();
        pulse_por();
        wait_cyc(6);
        expect_rails("R2 R6 R7 R8 run", 1, 1, 1);
        chk("R12 vsel captured", mem_sel_o, 1);
    endtask

    task automatic t_light_and_block();
        set_req(1, 0);
        wait_cyc(20);
        chk("R3 early", state_o, 1);
        wait_cyc(SETTLE);
        expect_rails("R6 R7 R8 light", 2, 1, 1);
        set_req(0, 0);
        wait_cyc(SETTLE);
        chk("R5 light->deep blocked", state_o, 2);
        set_req(1, 0);
        wait_cyc(10);
        set_req(1, 1);
        wait_cyc(SETTLE);
        expect_rails("R3 back to run", 1, 1, 1);
    endtask

    task automatic t_glitch();
        set_req(1, 0);
        wait_cyc(15);
        set_req(1, 1);
        wait_cyc(SETTLE);
        chk("R3 glitch ignored", state_o, 1);
    endtask

    task automatic t_illegal();
        set_req(0, 1);
        wait_cyc(SETTLE);
        expect_rails("R4 illegal pair", 1, 1, 1);
        set_req(1, 1);
        wait_cyc(SETTLE);
    endtask

    task automatic t_skew();
        saw_light = 1'b0;
        set_req(1, 0);
        wait_cyc(15);
        set_req(0, 0);
        wait_cyc(SETTLE);
        expect_rails("R3 R6 R7 R8 skew deep", 3, 1, 1);
        chk("R3 no light on skew", saw_light, 0);
    endtask

    task automatic t_freeze_and_block();
        d33_drop_deep = 1'b0;
        d5_keep_sleep = 1'b0;
        wait_cyc(20);
        expect_rails("R10 frozen in deep", 3, 1, 1);
        set_req(1, 0);
        wait_cyc(SETTLE);
        chk("R5 deep->light blocked", state_o, 3);
        set_req(1, 1);
        wait_cyc(SETTLE);
        expect_rails("R10 run tracks", 1, 0, 0);
    endtask

    task automatic t_deep_alt_cfg();
        set_req(0, 0);
        wait_cyc(SETTLE);
        expect_rails("R6 R7 deep alt cfg", 3, 0, 0);
        set_req(1, 1);
        wait_cyc(SETTLE);
        set_req(1, 0);
        wait_cyc(SETTLE);
        expect_rails("R7 light 5V dropped", 2, 0, 0);
        set_req(1, 1);
        wait_cyc(SETTLE);
        chk("R3 run again", state_o, 1);
    endtask

    task automatic t_shutdown();
        shutdown = 1'b1;
        wait_cyc(5);
        expect_rails("R11 halted", 4, 0, 0);
        d33_drop_deep = 1'b1;
        d5_keep_sleep = 1'b1;
        set_req(1, 0);
        wait_cyc(6);
        shutdown = 1'b0;
        wait_cyc(6);
        expect_rails("R11 R10 R2 release to light", 2, 1, 1);
        set_req(1, 1);
        wait_cyc(SETTLE);
        chk("R3 run after halt", state_o, 1);
    endtask

    task automatic t_memsel();
        mem_sel = 1'b0;
        wait_cyc(5);
        chk("R12 held", mem_sel_o, 1);
        pulse_por();
        wait_cyc(3);
        chk("R12 recaptured", mem_sel_o, 0);
    endtask

    task automatic t_bbm();
        chk("R9 gap violations", bbm_err, 0);
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        t_reset();
        t_power_up();
        t_light_and_block();
        t_glitch();
        t_illegal();
        t_skew();
        t_freeze_and_block();
        t_deep_alt_cfg();
        t_shutdown();
        t_memsel();
        t_bbm();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule